// File: doc/BRIEF.md
# NAND Flash Bus Controller Registers

This block sits between a simple 32-bit register bus and an 8-bit NAND flash bus. Software sets the latch-enable, chip-enable, chip-select and write-enable bits in a mode register. Those bits drive the flash pins directly. Software then moves command, address and data bytes through a single data register. Every data-register access turns into one timed NAND strobe cycle: a write strobe when the mode allows writes, otherwise a read strobe. The requester is held off until the strobe and the data hold that follows it are both over.

A timing register sets the strobe width and the hold length. The two values are added to fixed offsets. The flash ready/busy line is synchronized and shown in a status register. A self-clearing reset register returns the controller to its idle settings. Register offsets can be spread out by a configurable address left shift. The error-correction mode bits are stored here and passed out to a separate ECC block.

Top module: `nand_bus_ctrl`

## Requirements
- R1: After reset the mode register reads 0 and the timing register reads 0x24 (HOLD=2, SPW=4'h4... see R6 for field positions; default HOLD=2 in bits 7:4, SPW=4 in bits 3:0). The flash pins sit idle: chip enable high, write and read strobes high, both latch enables low, output enable off.
- R2: The mode register sits at offset 0x04 and reads back what was written in bits 7:0. Its bits map to pins as follows:
  - bit 0 drives the command latch enable;
  - bit 1 drives the address latch enable;
  - bits 3:2 drive the chip-select output;
  - bits 6:5 drive the ECC mode output;
  - bit 4 drives chip enable with inverted sense: 1 drives the active-low pin low.
- R3: A write to the data register (offset 0x00) while mode bit 7, bit 0 or bit 1 is set produces one write strobe. The strobe stays low for SPW+1 cycles. The low 8 bits of the written word are driven on the flash data lines, with output enable set during both the strobe and the hold.
- R4: A data-register write while mode bits 7, 1 and 0 are all clear is acknowledged without any strobe.
- R5: A data-register read produces one read strobe, low for SPW+1 cycles. The byte on the flash data lines in the last strobe cycle is returned in bits 7:0, with the upper bits zero. Output enable stays off throughout.
- R6: The timing register sits at offset 0x14, with HOLD in bits 7:4 and SPW in bits 3:0. After the strobe, the hold lasts HOLD+2 cycles when the hold-add option is set and HOLD cycles otherwise. The acknowledge comes in the cycle after the hold ends. The two strobes are never low together.
- R7: An access to any register other than the data register is acknowledged in the cycle after it is accepted. The acknowledge is always a one-cycle pulse.
- R8: Status bit 7 at offset 0x08 reads 1 while the active-low ready/busy input is low. That input passes through two flops before it is reported.
- R9: Writing 1 to bit 0 of the reset register (offset 0x18) makes that bit read 1 for RST_CYCLES cycles, after which it clears itself. While the bit is set:
  - the mode register is held at 0;
  - the timing register is held at its defaults;
  - data accesses are acknowledged with no strobe.
- R10: Every offset is compared after a left shift by ADDR_SHIFT. An address that matches no register reads 0, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, held with its address and data until acknowledged |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_ack is high |
| bus_ack | output | 1 | One-cycle completion pulse |
| nand_io_in | input | 8 | Flash data lines, inbound |
| nand_io_out | output | 8 | Flash data lines, outbound |
| nand_io_oe | output | 1 | Output enable for the flash data lines |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_rb_n | input | 1 | Ready/busy from the flash, low while busy |
| nand_cs | output | 2 | Chip-select code |
| ecc_mode | output | 2 | ECC mode bits for the ECC block |

## Verification
The bench goes after several corner cases, each of which shows a specific fault when the design gets it wrong:
- A strobe one cycle short or long, which the per-clock model catches at once.
- A hold that leaves out the fixed offset, or adds it when the minimum field value of zero is programmed, which shows up as an early or late acknowledge.
- Data writes with no write-qualifying mode bit, which must leave the write strobe untouched; a decoder that ignores the mode would pulse it.
- A soft reset that fails to clear itself, fails to hold the mode and timing at their defaults, or still lets a strobe through.
- A ready/busy path with the wrong number of flops.
- Unshifted addresses that alias onto real registers.

// File: rtl/nbc_pkg.sv
package nbc_pkg;

  localparam logic [7:0] OFF_DATA = 8'h00;
  localparam logic [7:0] OFF_MODE = 8'h04;
  localparam logic [7:0] OFF_STAT = 8'h08;
  localparam logic [7:0] OFF_TIME = 8'h14;
  localparam logic [7:0] OFF_RST  = 8'h18;

  localparam int MB_CLE = 0;
  localparam int MB_ALE = 1;
  localparam int MB_CS  = 2;
  localparam int MB_CE  = 4;
  localparam int MB_ECC = 5;
  localparam int MB_WE  = 7;

  typedef enum logic [1:0] {SQ_IDLE, SQ_STROBE, SQ_HOLD, SQ_DONE} seq_state_t;

  // number of cycles the strobe stays low
  function automatic logic [4:0] strobe_len(input logic [3:0] spw);
    return {1'b0, spw} + 5'd1;
  endfunction

  // number of hold cycles after the strobe
  function automatic logic [4:0] hold_len(input logic [3:0] hold, input bit add);
    return {1'b0, hold} + (add ? 5'd2 : 5'd0);
  endfunction

endpackage

// File: rtl/nbc_rb_sync.sv
module nbc_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/nbc_regs.sv
module nbc_regs #(
  parameter logic [3:0] DEF_HOLD   = 4'd2,
  parameter logic [3:0] DEF_SPW    = 4'd4,
  parameter int         RST_CYCLES = 4,
  localparam int        RCW        = $clog2(RST_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_mode,
  input  logic       wr_time,
  input  logic       wr_rst,
  input  logic [7:0] wbyte,
  output logic [7:0] mode,
  output logic [7:0] timing,
  output logic       rst_busy
);
  localparam logic [7:0] TIME_DEF = {DEF_HOLD, DEF_SPW};

  logic [RCW-1:0] rst_cnt;
  logic           rst_start;

  assign rst_busy  = (rst_cnt != '0);
  assign rst_start = wr_rst && wbyte[0] && !rst_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_cnt <= '0;
      mode    <= '0;
      timing  <= TIME_DEF;
    end else begin
      if (rst_start)     rst_cnt <= RCW'(RST_CYCLES);
      else if (rst_busy) rst_cnt <= rst_cnt - 1'b1;

      if (rst_start || rst_busy) begin
        mode   <= '0;
        timing <= TIME_DEF;
      end else begin
        if (wr_mode) mode   <= wbyte;
        if (wr_time) timing <= wbyte;
      end
    end
  end

  AST_RST_HOLDS_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_busy |-> (mode == 8'h00 && timing == TIME_DEF)); // R9
  AST_RST_STARTS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_busy) |-> $past(wr_rst && wbyte[0])); // R9
endmodule

// File: rtl/nbc_strobe_seq.sv
module nbc_strobe_seq
  import nbc_pkg::*;
#(
  parameter bit HOLD_ADD = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       is_data,
  input  logic       is_write,
  input  logic       write_ok,
  input  logic       blocked,
  input  logic [7:0] wr_byte,
  input  logic [3:0] spw,
  input  logic [3:0] hold,
  input  logic [7:0] io_in,
  output logic       accept,
  output logic       ack,
  output logic       we_n,
  output logic       re_n,
  output logic       io_oe,
  output logic [7:0] io_out,
  output logic [7:0] rd_byte
);
  seq_state_t state;
  logic [4:0] cnt;
  logic       dir_wr;
  logic       start_strobe;
  logic       strobing;
  logic [4:0] hold_n;

  assign accept       = (state == SQ_IDLE) && req;
  assign start_strobe = accept && is_data && !blocked && (!is_write || write_ok);
  assign hold_n       = hold_len(hold, HOLD_ADD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SQ_IDLE;
      cnt     <= '0;
      dir_wr  <= 1'b0;
      io_out  <= '0;
      rd_byte <= '0;
    end else begin
      unique case (state)
        SQ_IDLE: if (accept) begin
          if (start_strobe) begin
            state  <= SQ_STROBE;
            cnt    <= strobe_len(spw) - 5'd1;
            dir_wr <= is_write;
            if (is_write) io_out <= wr_byte;
          end else begin
            state <= SQ_DONE;
          end
        end
        SQ_STROBE: if (cnt == '0) begin
          if (!dir_wr) rd_byte <= io_in;
          if (hold_n == '0) state <= SQ_DONE;
          else begin
            state <= SQ_HOLD;
            cnt   <= hold_n - 5'd1;
          end
        end else cnt <= cnt - 5'd1;
        SQ_HOLD: if (cnt == '0) state <= SQ_DONE;
                 else           cnt   <= cnt - 5'd1;
        SQ_DONE: state <= SQ_IDLE;
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign strobing = (state == SQ_STROBE);
  assign we_n     = !(strobing && dir_wr);
  assign re_n     = !(strobing && !dir_wr);
  assign io_oe    = dir_wr && (state == SQ_STROBE || state == SQ_HOLD);
  assign ack      = (state == SQ_DONE);

  // length of the current low-strobe run, kept for the width check
  logic [4:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_len <= '0;
    else if (strobing) run_len <= run_len + 5'd1;
    else               run_len <= '0;
  end

  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n && re_n) |-> (run_len == strobe_len(spw))); // R3
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (we_n || re_n)); // R6
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack); // R7
  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n |-> !io_oe); // R5
  AST_BLOCKED_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && blocked) |=> (ack && we_n && re_n)); // R9
endmodule

// File: rtl/nand_bus_ctrl.sv
module nand_bus_ctrl
  import nbc_pkg::*;
#(
  parameter int         AW         = 8,
  parameter int         ADDR_SHIFT = 1,
  parameter bit         HOLD_ADD   = 1'b1,
  parameter logic [3:0] DEF_HOLD   = 4'd2,
  parameter logic [3:0] DEF_SPW    = 4'd4,
  parameter int         RST_CYCLES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_req,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          bus_ack,
  input  logic [7:0]    nand_io_in,
  output logic [7:0]    nand_io_out,
  output logic          nand_io_oe,
  output logic          nand_cle,
  output logic          nand_ale,
  output logic          nand_ce_n,
  output logic          nand_we_n,
  output logic          nand_re_n,
  input  logic          nand_rb_n,
  output logic [1:0]    nand_cs,
  output logic [1:0]    ecc_mode
);
  function automatic logic hit(input logic [AW-1:0] a, input logic [7:0] off);
    return a == (AW'(off) << ADDR_SHIFT);
  endfunction

  logic sel_data, sel_mode, sel_stat, sel_time, sel_rst;
  assign sel_data = hit(bus_addr, OFF_DATA);
  assign sel_mode = hit(bus_addr, OFF_MODE);
  assign sel_stat = hit(bus_addr, OFF_STAT);
  assign sel_time = hit(bus_addr, OFF_TIME);
  assign sel_rst  = hit(bus_addr, OFF_RST);

  logic       accept, rst_busy, rb_sync;
  logic [7:0] mode, timing, rd_byte;
  logic       reg_write;
  logic       unused_hi;

  assign unused_hi = ^bus_wdata[31:8];
  assign reg_write = accept && bus_wr;

  nbc_rb_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(nand_rb_n), .dout(rb_sync)
  );

  nbc_regs #(.DEF_HOLD(DEF_HOLD), .DEF_SPW(DEF_SPW), .RST_CYCLES(RST_CYCLES)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_mode(reg_write && sel_mode),
    .wr_time(reg_write && sel_time),
    .wr_rst(reg_write && sel_rst),
    .wbyte(bus_wdata[7:0]),
    .mode(mode), .timing(timing), .rst_busy(rst_busy)
  );

  nbc_strobe_seq #(.HOLD_ADD(HOLD_ADD)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req(bus_req), .is_data(sel_data), .is_write(bus_wr),
    .write_ok(mode[MB_WE] || mode[MB_CLE] || mode[MB_ALE]),
    .blocked(rst_busy), .wr_byte(bus_wdata[7:0]),
    .spw(timing[3:0]), .hold(timing[7:4]), .io_in(nand_io_in),
    .accept(accept), .ack(bus_ack), .we_n(nand_we_n), .re_n(nand_re_n),
    .io_oe(nand_io_oe), .io_out(nand_io_out), .rd_byte(rd_byte)
  );

  always_comb begin
    bus_rdata = '0;
    if (sel_data)      bus_rdata[7:0] = rd_byte;
    else if (sel_mode) bus_rdata[7:0] = mode;
    else if (sel_stat) bus_rdata[7]   = !rb_sync;
    else if (sel_time) bus_rdata[7:0] = timing;
    else if (sel_rst)  bus_rdata[0]   = rst_busy;
  end

  assign nand_cle  = mode[MB_CLE];
  assign nand_ale  = mode[MB_ALE];
  assign nand_ce_n = !mode[MB_CE];
  assign nand_cs   = mode[MB_CS +: 2];
  assign ecc_mode  = mode[MB_ECC +: 2];

  AST_IDLE_PINS_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    rst_busy |-> (nand_ce_n && !nand_cle && !nand_ale)); // R9
endmodule

// File: tb/sim_nand_bus_ctrl.sv
`timescale 1ns/1ps
module sim_nand_bus_ctrl;
  localparam int AW = 8;
  localparam int SH = 1;
  localparam int RSTN = 4;
  localparam logic [7:0] TDEF = 8'h24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_req = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_ack;
  logic [7:0] nand_io_in = 8'h00, nand_io_out;
  logic nand_io_oe, nand_cle, nand_ale, nand_ce_n, nand_we_n, nand_re_n;
  logic nand_rb_n = 1'b1;
  logic [1:0] nand_cs, ecc_mode;

  always #10 clk = ~clk;

  nand_bus_ctrl #(.AW(AW), .ADDR_SHIFT(SH), .HOLD_ADD(1'b1), .DEF_HOLD(4'd2),
                  .DEF_SPW(4'd4), .RST_CYCLES(RSTN)) u0 (.*);

  int checks = 0, errors = 0, cycles = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] A(input int off);
    return AW'(off * (1 << SH));
  endfunction

  // ---------------- behavioural reference model ----------------
  // phases: 0 idle, 1 strobe, 2 hold, 3 acknowledge
  int q[$];
  int m_cur = 0, m_rst = 0;
  bit m_wr = 0, rb1 = 1, rb2 = 1;
  logic [7:0] m_mode = 0, m_tim = TDEF, m_byte = 0, m_rd = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); m_cur = 0; m_rst = 0; m_wr = 0; rb1 = 1; rb2 = 1;
      m_mode = 0; m_tim = TDEF; m_byte = 0; m_rd = 0;
    end else begin
      int old_rst = m_rst;
      bit start_rst = 0;
      rb2 = rb1; rb1 = nand_rb_n;
      if (m_rst > 0) m_rst--;
      if (q.size() > 0) m_cur = q.pop_front();
      else if (m_cur == 3) m_cur = 0;
      else if (bus_req) begin
        if (bus_addr == A(0)) begin
          if (old_rst == 0 && (!bus_wr || m_mode[7] || m_mode[0] || m_mode[1])) begin
            for (int i = 0; i <= int'(m_tim[3:0]); i++) q.push_back(1);
            for (int i = 0; i < int'(m_tim[7:4]) + 2; i++) q.push_back(2);
            q.push_back(3);
            m_wr = bus_wr;
            if (bus_wr) m_byte = bus_wdata[7:0]; else m_rd = nand_io_in;
            m_cur = q.pop_front();
          end else m_cur = 3;
        end else begin
          m_cur = 3;
          if (bus_wr && bus_addr == A(8'h18) && bus_wdata[0] && old_rst == 0) begin
            m_rst = RSTN; start_rst = 1;
          end
          if (bus_wr && old_rst == 0 && !start_rst) begin
            if (bus_addr == A(8'h04)) m_mode = bus_wdata[7:0];
            if (bus_addr == A(8'h14)) m_tim = bus_wdata[7:0];
          end
        end
      end
      if (old_rst > 0 || start_rst) begin m_mode = 0; m_tim = TDEF; end
    end
  end

  function automatic logic [31:0] exp_rdata(input logic [AW-1:0] a);
    if (a == A(0))     return {24'h0, m_rd};
    if (a == A(8'h04)) return {24'h0, m_mode};
    if (a == A(8'h08)) return {24'h0, !rb2, 7'h0};
    if (a == A(8'h14)) return {24'h0, m_tim};
    if (a == A(8'h18)) return {31'h0, m_rst != 0};
    return 32'h0; // R10
  endfunction

  // compare on every clock, away from the active edge
  always @(negedge clk) if (rst_n && !done) begin
    logic ewe, ere, eoe;
    ewe = !(m_cur == 1 && m_wr);
    ere = !(m_cur == 1 && !m_wr);
    eoe = (m_cur == 1 || m_cur == 2) && m_wr;
    check({nand_we_n, nand_re_n, nand_io_oe} == {ewe, ere, eoe}, "R3/R5/R6 strobe pins",
          {29'h0, nand_we_n, nand_re_n, nand_io_oe}, {29'h0, ewe, ere, eoe});
    if (eoe) check(nand_io_out == m_byte, "R3 data lines", {24'h0, nand_io_out}, {24'h0, m_byte});
    check(bus_ack == (m_cur == 3), "R6/R7 acknowledge", {31'h0, bus_ack}, {31'h0, m_cur == 3});
    check({nand_cle, nand_ale, nand_ce_n, nand_cs, ecc_mode} ==
          {m_mode[0], m_mode[1], !m_mode[4], m_mode[3:2], m_mode[6:5]}, "R2 mode pins",
          {25'h0, nand_cle, nand_ale, nand_ce_n, nand_cs, ecc_mode},
          {25'h0, m_mode[0], m_mode[1], !m_mode[4], m_mode[3:2], m_mode[6:5]});
    if (bus_ack && !bus_wr)
      check(bus_rdata == exp_rdata(bus_addr), "R5/R8/R9/R10 read data", bus_rdata, exp_rdata(bus_addr));
  end

  // ---------------- stimulus ----------------
  int we_lows = 0;
  always @(negedge clk) if (!nand_we_n) we_lows++;

  task automatic access(input bit wr, input int off, input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    bus_req = 1; bus_wr = wr; bus_addr = AW'(off); bus_wdata = wd;
    do @(negedge clk); while (!bus_ack && !done);
    rd = bus_rdata;
    bus_req = 0;
  endtask

  task automatic wr_reg(input int off, input logic [31:0] wd);
    logic [31:0] d;
    access(1, off, wd, d);
  endtask

  task automatic rd_reg(input int off, input logic [31:0] exp, input string req);
    logic [31:0] d;
    access(0, off, 0, d);
    check(d == exp, req, d, exp);
  endtask

  task automatic timed_write(input logic [7:0] tim, input logic [31:0] wd);
    int t0, t1;
    wr_reg(A(8'h14), {24'h0, tim});
    @(negedge clk);
    bus_req = 1; bus_wr = 1; bus_addr = A(0); bus_wdata = wd;
    t0 = cycles;
    do @(negedge clk); while (!bus_ack && !done);
    t1 = cycles;
    bus_req = 0;
    // strobe SPW+1, hold HOLD+2, then the acknowledge cycle
    check(t1 - t0 == int'(tim[3:0]) + 1 + int'(tim[7:4]) + 2 + 1, "R6 strobe+hold length",
          t1 - t0, int'(tim[3:0]) + int'(tim[7:4]) + 4);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: idle state after reset
    check({nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_io_oe} == 6'b111000,
          "R1 idle pins", {26'h0, nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_io_oe}, 32'h38);
    rd_reg(A(8'h14), TDEF, "R1 timing default");
    rd_reg(A(8'h04), 0, "R1 mode default");

    // R2 / R3: command byte with CE and CLE set
    wr_reg(A(8'h04), 32'h11);
    check(nand_ce_n == 0 && nand_cle == 1, "R2 CE inverted, CLE", {30'h0, nand_ce_n, nand_cle}, 32'h1);
    wr_reg(A(0), 32'hDEAD_BE70);
    wr_reg(A(8'h04), 32'h12);
    wr_reg(A(0), 32'h0000_0005);
    // R4: no write qualifier -> no strobe
    wr_reg(A(8'h04), 32'h10);
    base = we_lows;
    wr_reg(A(0), 32'h0000_00AB);
    check(we_lows == base, "R4 write ignored", we_lows - base, 0);

    // R3 / R6: data writes under several timings
    wr_reg(A(8'h04), 32'h90);
    timed_write(8'h10, 32'h5A);
    timed_write(8'hF5, 32'hC3);
    timed_write(8'h03, 32'h0F);
    timed_write(8'h21, 32'hFF);

    // R5: data read
    nand_io_in = 8'hC3;
    access(0, A(0), 0, d);
    check(d == 32'hC3, "R5 read byte", d, 32'hC3);
    nand_io_in = 8'h3C;
    wr_reg(A(8'h14), 32'h00);
    access(0, A(0), 0, d);
    check(d == 32'h3C, "R5 read byte minimal timing", d, 32'h3C);

    // R2: chip select and ECC mode
    wr_reg(A(8'h04), 32'h7C);
    check(nand_cs == 2'b11 && ecc_mode == 2'b11, "R2 cs/ecc", {28'h0, nand_cs, ecc_mode}, 32'hF);
    rd_reg(A(8'h04), 32'h7C, "R2 mode readback");

    // R8: ready/busy through two flops
    nand_rb_n = 0;
    repeat (3) @(negedge clk);
    rd_reg(A(8'h08), 32'h80, "R8 busy");
    nand_rb_n = 1;
    repeat (3) @(negedge clk);
    rd_reg(A(8'h08), 32'h00, "R8 ready");

    // R9: self-clearing reset
    wr_reg(A(8'h04), 32'h93);
    wr_reg(A(8'h14), 32'h11);
    wr_reg(A(8'h18), 32'h1);
    check(nand_ce_n == 1 && nand_cle == 0 && nand_ale == 0, "R9 idle pins in reset",
          {29'h0, nand_ce_n, nand_cle, nand_ale}, 32'h4);
    base = we_lows;
    wr_reg(A(0), 32'h77);
    check(we_lows == base, "R9 data blocked", we_lows - base, 0);
    repeat (RSTN) @(negedge clk);
    rd_reg(A(8'h18), 32'h0, "R9 reset cleared");
    rd_reg(A(8'h04), 32'h0, "R9 mode cleared");
    rd_reg(A(8'h14), TDEF, "R9 timing default");

    // R10: unshifted offset aliases nothing
    wr_reg(8'h04, 32'hFF);
    rd_reg(8'h04, 32'h0, "R10 unmapped reads 0");
    rd_reg(A(8'h04), 32'h0, "R10 mode untouched");

    repeat (4) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule